// File: doc/BRIEF.md
# Two-Channel PWM Timer

A 16-bit timer whose single counter drives two pulse-width-modulated outputs. The counter advances on a tick taken from one of three enable sources: every system clock, a fixed-frequency strobe, or an external strobe. That tick is divided by a power of two before it reaches the counter. The counter runs between a programmable base value and a programmable top value. It either counts up and restarts (edge-aligned) or climbs to the top and falls back to the base (center-aligned).

Each channel compares the count against its own threshold. The output is active while the count is below the threshold. A per-channel polarity bit and a per-channel mask bit then shape the output. Software programs everything through a plain synchronous write port. A lock register must be opened before any other register accepts a write. New top and threshold values are held in shadow copies and take effect only at a period boundary, so a running waveform never shows a partial period.

Register map (address: content). 0: lock, bit 0 = 1 opens writes. 1: control. 2: base. 3: top. 4: channel options. 5 + i: threshold of channel i.

Top module: `dual_pwm_timer`

## Requirements
- R1: In up mode (control bit 5 = 0), one period lasts (top − base + 1) counter ticks, with the count stepping base, base+1, …, top.
- R2: In up mode, channel i is active for (threshold_i − base) ticks of each period when base < threshold_i ≤ top.
- R3: Control bits [4:2] hold a value n, and one counter tick is issued every 2^n selected source pulses, covering n = 0 (divide by 1) through n = 7 (divide by 128).
- R4: Control bits [1:0] pick the source. 00 means no source: the count does not advance, it rests at the base value, and written values take effect at once. 01 means every clock, 10 means the fixed-frequency strobe, and 11 means the external strobe.
- R5: Control bit 5 selects up counting when 0 and up-down counting when 1.
- R6: In up-down mode the count runs base → top → base with a period of 2 × (top − base) ticks. A channel is active in each tick whose count is below its threshold, which gives 2 × (threshold − base) − 1 active ticks per period.
- R7: Option bit i (polarity of channel i) gives an active-high output when 0 and an active-low output when 1.
- R8: Option bit 8 + i (mask of channel i) = 1 holds that output at its inactive level: 0 with polarity 0, 1 with polarity 1. When the mask bit is 0, the channel runs normally.
- R9: Writes to addresses other than 0 are ignored unless bit 0 of the lock register (address 0) is 1. Address 0 is always writable, and after reset it is 0.
- R10: Top, base and threshold writes made while the counter runs take effect only at the next period boundary.
- R11: A threshold equal to the base gives 0 % duty (constant inactive). A threshold above the top gives 100 % duty (constant active). After reset both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 16 | Register write data |
| fix_en_i | input | 1 | Fixed-frequency enable strobe, one clock wide |
| ext_en_i | input | 1 | External enable strobe, synchronous, one clock wide |
| pwm_o | output | 2 | PWM outputs, bit i is channel i |

## Verification
The assertions assume that the top value is at least the base value, and strictly above it in up-down mode. They also assume that both strobes are synchronous one-clock pulses, and that the prescale field changes only while the source is off. The stimulus respects these limits. Every configuration is loaded with the source set to 00, and the source is enabled last. Random cases draw the base, a positive span to the top, and a threshold strictly inside the period. Separate directed cases then cover thresholds at the base and above the top, the largest divider, writes made mid-period, and writes made while the lock is closed.

// File: rtl/pwm_timer_pkg.sv
`timescale 1ns/1ps
// Package: shared types and register addresses for the two-channel PWM timer.
// Assumes: the address constants fit the ADDR_W of the register block.
package pwm_timer_pkg;

    typedef enum logic [1:0] {
        CLK_OFF = 2'b00,
        CLK_SYS = 2'b01,
        CLK_FIX = 2'b10,
        CLK_EXT = 2'b11
    } clk_src_e;

    localparam int unsigned A_LOCK = 0;
    localparam int unsigned A_CTRL = 1;
    localparam int unsigned A_BASE = 2;
    localparam int unsigned A_TOP  = 3;
    localparam int unsigned A_OPT  = 4;
    localparam int unsigned A_CMP0 = 5;

    localparam int unsigned MASK_LSB = 8;

endpackage

// File: rtl/pwm_cfg_regs.sv
`timescale 1ns/1ps
// Module: configuration register file with a write lock.
// What it does: captures control, base, top, option and threshold words from a
//   synchronous write port. Only the lock register is writable while locked.
// Assumes: NUM_CH <= MASK_LSB and MASK_LSB + NUM_CH <= CNT_W.
module pwm_cfg_regs
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 2,
    parameter int PS_W   = 3,
    parameter int ADDR_W = 4
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    wr_en_i,
    input  logic [ADDR_W-1:0]       wr_addr_i,
    input  logic [CNT_W-1:0]        wr_data_i,
    output clk_src_e                clk_src_o,
    output logic [PS_W-1:0]         ps_o,
    output logic                    updown_o,
    output logic [CNT_W-1:0]        base_o,
    output logic [CNT_W-1:0]        top_o,
    output logic [NUM_CH-1:0]       pol_o,
    output logic [NUM_CH-1:0]       mask_o,
    output logic [NUM_CH*CNT_W-1:0] cmp_o
);

    localparam int MODE_BIT = 2 + PS_W;

    logic unlock;
    logic wr_ok;

    assign wr_ok = wr_en_i && unlock;

    // Purpose: open or close the write lock; always writable.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            unlock <= 1'b0;
        end else if (wr_en_i && wr_addr_i == ADDR_W'(A_LOCK)) begin
            unlock <= wr_data_i[0];
        end
    end

    // Purpose: capture the shared timer settings when unlocked.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            clk_src_o <= CLK_OFF;
            ps_o      <= '0;
            updown_o  <= 1'b0;
            base_o    <= '0;
            top_o     <= '1;
            pol_o     <= '0;
            mask_o    <= '0;
        end else if (wr_ok) begin
            if (wr_addr_i == ADDR_W'(A_CTRL)) begin
                clk_src_o <= clk_src_e'(wr_data_i[1:0]);
                ps_o      <= wr_data_i[2 +: PS_W];
                updown_o  <= wr_data_i[MODE_BIT];
            end
            if (wr_addr_i == ADDR_W'(A_BASE)) begin
                base_o <= wr_data_i;
            end
            if (wr_addr_i == ADDR_W'(A_TOP)) begin
                top_o <= wr_data_i;
            end
            if (wr_addr_i == ADDR_W'(A_OPT)) begin
                pol_o  <= wr_data_i[NUM_CH-1:0];
                mask_o <= wr_data_i[MASK_LSB +: NUM_CH];
            end
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
        // Purpose: capture the threshold of channel g when unlocked.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                cmp_o[g*CNT_W +: CNT_W] <= '0;
            end else if (wr_ok && wr_addr_i == ADDR_W'(A_CMP0 + g)) begin
                cmp_o[g*CNT_W +: CNT_W] <= wr_data_i;
            end
        end
    end

    // R9: a locked write to any other address leaves every setting unchanged
    p_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i != ADDR_W'(A_LOCK) && !unlock) |=>
            ($stable(base_o) && $stable(top_o) && $stable(cmp_o) &&
             $stable(ps_o) && $stable(pol_o) && $stable(mask_o) &&
             $stable(updown_o) && $stable(clk_src_o)));

endmodule

// File: rtl/pwm_tick_gen.sv
`timescale 1ns/1ps
// Module: clock-source select and power-of-two prescaler.
// What it does: picks one enable source and emits one tick per 2^ps_i
//   selected pulses. With source CLK_OFF it emits nothing and clears its divider.
// Assumes: fix_en_i and ext_en_i are synchronous pulses; ps_i changes only
//   while the source is off.
module pwm_tick_gen
    import pwm_timer_pkg::*;
#(
    parameter int PS_W = 3
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  clk_src_e        clk_src_i,
    input  logic [PS_W-1:0] ps_i,
    input  logic            fix_en_i,
    input  logic            ext_en_i,
    output logic            tick_o,
    output logic            running_o
);

    localparam int DIV_W = (1 << PS_W) - 1;

    logic             src_en;
    logic [DIV_W-1:0] pcnt;
    logic [DIV_W-1:0] div_mask;

    // Purpose: route the selected enable source.
    always_comb begin
        unique case (clk_src_i)
            CLK_SYS: src_en = 1'b1;
            CLK_FIX: src_en = fix_en_i;
            CLK_EXT: src_en = ext_en_i;
            default: src_en = 1'b0;
        endcase
    end

    assign running_o = (clk_src_i != CLK_OFF);
    assign div_mask  = (DIV_W'(1) << ps_i) - DIV_W'(1);
    assign tick_o    = src_en && ((pcnt & div_mask) == div_mask);

    // Purpose: count source pulses between ticks.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !running_o) begin
            pcnt <= '0;
        end else if (tick_o) begin
            pcnt <= '0;
        end else if (src_en) begin
            pcnt <= pcnt + DIV_W'(1);
        end
    end

    // R4: no tick while no source is selected
    p_off_no_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clk_src_i == CLK_OFF) |-> !tick_o);

    // R3: with any division above one, ticks are never back to back
    p_prescale_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && ps_i != '0) |=> (!tick_o || ps_i != $past(ps_i)));

endmodule

// File: rtl/pwm_counter.sv
`timescale 1ns/1ps
// Module: shared period counter with shadowed base and top.
// What it does: counts up (wrapping at top) or up-down (turning at top and
//   base). It loads the written base/top at each period boundary, and
//   continuously while stopped, where it also rests at the base.
// Assumes: top >= base, and top > base in up-down mode.
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             running_i,
    input  logic             updown_i,
    input  logic [CNT_W-1:0] base_n_i,
    input  logic [CNT_W-1:0] top_n_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             load_o
);

    logic [CNT_W-1:0] base_a;
    logic [CNT_W-1:0] top_a;
    logic [CNT_W-1:0] nxt;
    logic             dir_up;
    logic             nxt_up;
    logic             wrap;

    // Purpose: next count, next direction and period-boundary detection.
    always_comb begin
        nxt    = cnt_o + CNT_W'(1);
        nxt_up = 1'b1;
        wrap   = 1'b0;
        if (!updown_i) begin
            wrap = (cnt_o == top_a);
        end else if (dir_up) begin
            if (cnt_o == top_a) begin
                if (top_a == base_a) begin
                    wrap = 1'b1;
                end else begin
                    nxt    = top_a - CNT_W'(1);
                    nxt_up = 1'b0;
                    wrap   = ((top_a - CNT_W'(1)) == base_a);
                end
            end
        end else begin
            nxt    = cnt_o - CNT_W'(1);
            nxt_up = 1'b0;
            wrap   = (nxt == base_a);
        end
        if (wrap) begin
            nxt_up = 1'b1;
        end
    end

    assign load_o = !running_i || (tick_i && wrap);

    // Purpose: advance the count and refresh the active base/top at boundaries.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_o  <= '0;
            dir_up <= 1'b1;
            base_a <= '0;
            top_a  <= '1;
        end else if (!running_i) begin
            cnt_o  <= base_n_i;
            dir_up <= 1'b1;
            base_a <= base_n_i;
            top_a  <= top_n_i;
        end else if (tick_i) begin
            dir_up <= nxt_up;
            if (wrap) begin
                cnt_o  <= base_n_i;
                base_a <= base_n_i;
                top_a  <= top_n_i;
            end else begin
                cnt_o <= nxt;
            end
        end
    end

    // R1: in up mode each tick inside a period steps the count by one
    p_up_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running_i && tick_i && !updown_i && !wrap) |=>
            (cnt_o == $past(cnt_o) + CNT_W'(1)));

    // R6: in up-down mode each tick inside a period moves the count by one
    p_ud_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running_i && tick_i && updown_i && !wrap) |=>
            ((cnt_o == $past(cnt_o) + CNT_W'(1)) ||
             (cnt_o == $past(cnt_o) - CNT_W'(1))));

    // R4: without a tick a running count holds its value
    p_halt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running_i && !tick_i) |=> (cnt_o == $past(cnt_o)));

    // R10: every new period starts at the freshly written base
    p_wrap_base_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_o |=> (cnt_o == $past(base_n_i)));

endmodule

// File: rtl/pwm_channel_out.sv
`timescale 1ns/1ps
// Module: one PWM output stage.
// What it does: keeps a shadow threshold that is loaded on load_i. It compares
//   the count against that threshold and applies mask and polarity to a
//   registered output.
// Assumes: load_i pulses exactly at period boundaries, or stays high while stopped.
module pwm_channel_out #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_n_i,
    input  logic             load_i,
    input  logic             pol_i,
    input  logic             mask_i,
    output logic             pwm_o
);

    logic [CNT_W-1:0] cmp_a;
    logic             active;

    assign active = (cnt_i < cmp_a);

    // Purpose: adopt a new threshold only at a period boundary.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cmp_a <= '0;
        end else if (load_i) begin
            cmp_a <= cmp_n_i;
        end
    end

    // Purpose: drive the output with mask and polarity applied.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pwm_o <= 1'b0;
        end else if (mask_i) begin
            pwm_o <= pol_i;
        end else begin
            pwm_o <= active ^ pol_i;
        end
    end

    // R8: a masked channel sits at its inactive level
    p_mask_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mask_i |=> (pwm_o == $past(pol_i)));

    // R10: the working threshold changes only on a boundary load
    p_hold_cmp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(cmp_a));

endmodule

// File: rtl/dual_pwm_timer.sv
`timescale 1ns/1ps
// Module: two-channel PWM timer, top level.
// What it does: ties the register file, tick generator, shared counter and
//   NUM_CH output stages together.
// Assumes: synchronous single-clock use; strobes are one clock wide.
module dual_pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 2,
    parameter int PS_W   = 3,
    parameter int ADDR_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    input  logic              fix_en_i,
    input  logic              ext_en_i,
    output logic [NUM_CH-1:0] pwm_o
);

    clk_src_e                clk_src;
    logic [PS_W-1:0]         ps;
    logic                    updown;
    logic [CNT_W-1:0]        base_n;
    logic [CNT_W-1:0]        top_n;
    logic [NUM_CH-1:0]       pol;
    logic [NUM_CH-1:0]       mask;
    logic [NUM_CH*CNT_W-1:0] cmp_n;
    logic                    tick;
    logic                    running;
    logic [CNT_W-1:0]        cnt;
    logic                    load;

    pwm_cfg_regs #(
        .CNT_W  (CNT_W),
        .NUM_CH (NUM_CH),
        .PS_W   (PS_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .clk_src_o (clk_src),
        .ps_o      (ps),
        .updown_o  (updown),
        .base_o    (base_n),
        .top_o     (top_n),
        .pol_o     (pol),
        .mask_o    (mask),
        .cmp_o     (cmp_n)
    );

    pwm_tick_gen #(
        .PS_W (PS_W)
    ) u_tick (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clk_src_i (clk_src),
        .ps_i      (ps),
        .fix_en_i  (fix_en_i),
        .ext_en_i  (ext_en_i),
        .tick_o    (tick),
        .running_o (running)
    );

    pwm_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick),
        .running_i (running),
        .updown_i  (updown),
        .base_n_i  (base_n),
        .top_n_i   (top_n),
        .cnt_o     (cnt),
        .load_o    (load)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_channel_out #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .cnt_i   (cnt),
            .cmp_n_i (cmp_n[g*CNT_W +: CNT_W]),
            .load_i  (load),
            .pol_i   (pol[g]),
            .mask_i  (mask[g]),
            .pwm_o   (pwm_o[g])
        );
    end

endmodule

// File: tb/dual_pwm_timer_bench.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random configurations for dual_pwm_timer.
module dual_pwm_timer_bench;

    localparam int LIM = 40000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        fix_en = 1'b0;
    logic        ext_en = 1'b0;
    logic [1:0]  pwm;

    int n_chk = 0;
    int n_fail = 0;
    int fc = 0;
    int ec = 0;

    always #2 clk = ~clk;

    dual_pwm_timer u_dual_pwm_timer (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .fix_en_i  (fix_en),
        .ext_en_i  (ext_en),
        .pwm_o     (pwm)
    );

    // fixed strobe every 3 clocks, external strobe every 5 clocks
    always @(negedge clk) begin
        fc = (fc == 2) ? 0 : fc + 1;
        ec = (ec == 4) ? 0 : ec + 1;
        fix_en <= (fc == 0);
        ext_en <= (ec == 0);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a[3:0];
        wr_data = d[15:0];
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic cfg(input int sel, input int ps, input int ud, input int base,
                       input int top, input int opt, input int c0, input int c1);
        wr(1, (ud << 5) | (ps << 2));
        wr(2, base);
        wr(3, top);
        wr(4, opt);
        wr(5, c0);
        wr(6, c1);
        wr(1, (ud << 5) | (ps << 2) | sel);
    endtask

    function automatic int exp_per(int ud, int base, int top, int ps, int div);
        return (ud != 0 ? 2 * (top - base) : (top - base + 1)) * (1 << ps) * div;
    endfunction

    function automatic int exp_act(int ud, int base, int cmp, int ps, int div);
        return (ud != 0 ? 2 * (cmp - base) - 1 : (cmp - base)) * (1 << ps) * div;
    endfunction

    task automatic measure(input int ch, input bit lvl, output int act,
                           output int per, output bit ok);
        int guard = 0;
        int inact = 0;
        act = 0;
        while (pwm[ch] == lvl && guard < LIM) begin @(negedge clk); guard++; end
        while (pwm[ch] != lvl && guard < LIM) begin @(negedge clk); guard++; end
        while (pwm[ch] == lvl && guard < LIM) begin @(negedge clk); guard++; act++; end
        while (pwm[ch] != lvl && guard < LIM) begin @(negedge clk); guard++; inact++; end
        per = act + inact;
        ok  = (guard < LIM);
    endtask

    task automatic expect_wave(input int ch, input bit lvl, input int ea,
                               input int ep, input string req);
        int a;
        int p;
        bit ok;
        measure(ch, lvl, a, p, ok);
        check(ok && a == ea, {req, " active cycles"}, ok ? a : -1, ea);
        check(ok && p == ep, {req, " period cycles"}, ok ? p : -1, ep);
    endtask

    task automatic expect_const(input int ch, input bit val, input int n, input string req);
        int bad = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pwm[ch] != val) bad++;
        end
        check(bad == 0, req, bad == 0 ? int'(val) : int'(!val), int'(val));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog all requirements", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd7321);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state, threshold equals base, both outputs 0
        check(pwm == 2'b00, "R11 reset outputs", int'(pwm), 0);

        // R9: writes while locked are dropped
        wr(5, 40);
        wr(1, 1);
        repeat (20) @(negedge clk);
        check(pwm == 2'b00, "R9 locked write ignored", int'(pwm), 0);
        wr(0, 1);

        // R1 R2: up mode, system clock, divide by 1
        cfg(1, 0, 0, 5, 24, 0, 12, 20);
        expect_wave(0, 1'b1, exp_act(0, 5, 12, 0, 1), exp_per(0, 5, 24, 0, 1), "R1 R2 ch0");
        expect_wave(1, 1'b1, exp_act(0, 5, 20, 0, 1), exp_per(0, 5, 24, 0, 1), "R2 ch1");

        // R3: largest divider, 128
        cfg(1, 7, 0, 0, 3, 0, 2, 2);
        expect_wave(0, 1'b1, exp_act(0, 0, 2, 7, 1), exp_per(0, 0, 3, 7, 1), "R3 div128");

        // R4: fixed-frequency source (every 3 clocks) with divide by 2
        cfg(2, 1, 0, 0, 9, 0, 4, 4);
        expect_wave(0, 1'b1, exp_act(0, 0, 4, 1, 3), exp_per(0, 0, 9, 1, 3), "R4 fixed src");
        // R4: external source (every 5 clocks)
        cfg(3, 0, 0, 0, 9, 0, 4, 4);
        expect_wave(1, 1'b1, exp_act(0, 0, 4, 0, 5), exp_per(0, 0, 9, 0, 5), "R4 ext src");
        // R4: no source halts at base, base 10 < 20 active, 5 not
        cfg(0, 0, 0, 10, 30, 0, 20, 5);
        expect_const(0, 1'b1, 100, "R4 halted ch0 at base");
        expect_const(1, 1'b0, 20, "R4 halted ch1 at base");

        // R5 R6: up-down mode
        cfg(1, 0, 1, 2, 12, 0, 5, 12);
        expect_wave(0, 1'b1, exp_act(1, 2, 5, 0, 1), exp_per(1, 2, 12, 0, 1), "R5 R6 ch0");
        expect_wave(1, 1'b1, exp_act(1, 2, 12, 0, 1), exp_per(1, 2, 12, 0, 1), "R6 ch1");

        // R11: threshold at base and above top, both modes
        cfg(1, 0, 0, 10, 30, 0, 10, 31);
        expect_const(0, 1'b0, 80, "R11 up zero duty");
        expect_const(1, 1'b1, 80, "R11 up full duty");
        cfg(1, 0, 1, 10, 30, 0, 10, 31);
        expect_const(0, 1'b0, 100, "R11 updown zero duty");
        expect_const(1, 1'b1, 100, "R11 updown full duty");

        // R7: polarity of ch0 set, active level low
        cfg(1, 0, 0, 0, 19, 32'h1, 6, 6);
        expect_wave(0, 1'b0, 6, 20, "R7 active low");
        expect_wave(1, 1'b1, 6, 20, "R7 ch1 unaffected");

        // R8: mask bit 8 on ch0, inactive level follows polarity
        cfg(1, 0, 0, 0, 19, 32'h100, 6, 6);
        expect_const(0, 1'b0, 60, "R8 masked pol0");
        expect_wave(1, 1'b1, 6, 20, "R8 ch1 unmasked");
        cfg(1, 0, 0, 0, 19, 32'h101, 6, 6);
        expect_const(0, 1'b1, 60, "R8 masked pol1");

        // R10: threshold raised mid-period waits for the boundary
        cfg(1, 0, 0, 0, 99, 0, 50, 50);
        expect_wave(0, 1'b1, 50, 100, "R10 before update");
        begin
            int guard = 0;
            while (pwm[0] != 1'b0 && guard < LIM) begin @(negedge clk); guard++; end
            while (pwm[0] != 1'b1 && guard < LIM) begin @(negedge clk); guard++; end
        end
        repeat (60) @(negedge clk);
        wr(5, 80);
        expect_const(0, 1'b0, 30, "R10 no change mid-period");
        expect_wave(0, 1'b1, 80, 100, "R10 after boundary");

        // R9: lock, attempt a write, unlock; the old threshold remains
        wr(0, 0);
        wr(5, 10);
        wr(0, 1);
        repeat (250) @(negedge clk);
        expect_wave(0, 1'b1, 80, 100, "R9 locked write dropped");

        // random configurations against the period and duty formulas
        for (int it = 0; it < 10; it++) begin
            int base = $urandom % 41;
            int span = 4 + $urandom % 37;
            int top  = base + span;
            int c0   = base + 1 + $urandom % span;
            int c1   = base + 1 + $urandom % span;
            int ps   = $urandom % 3;
            int sel  = 1 + $urandom % 3;
            int ud   = $urandom % 2;
            int pl   = $urandom % 4;
            int div  = (sel == 1) ? 1 : ((sel == 2) ? 3 : 5);
            cfg(sel, ps, ud, base, top, pl, c0, c1);
            expect_wave(0, !pl[0], exp_act(ud, base, c0, ps, div),
                        exp_per(ud, base, top, ps, div), "R1 R6 R7 random ch0");
            expect_wave(1, !pl[1], exp_act(ud, base, c1, ps, div),
                        exp_per(ud, base, top, ps, div), "R2 R3 R5 random ch1");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule